// File: doc/BRIEF.md
# Table-Routed Four-Port Packet Router

This block is a small on-chip packet router with four input ports and four output ports. Every input owns a private packet queue. Each cycle a rotating scanner picks one non-empty queue and moves that queue's oldest packet through a shared selector. The packet's identifier indexes a fixed routing table, and the table returns one output port. On the cycle after the pick, the packet appears on that port alone, together with a one-cycle valid pulse.

The router holds five complete routing tables, all fixed at build time. Table 0 is the normal route set. Tables 1 to 4 are fallback route sets that move traffic away from one output direction, so a link that has failed can be avoided. A 3-bit select input chooses the active table, and it can be changed while the router runs.

A packet whose identifier has no entry in the active table is discarded. So is any packet picked while the select input holds a value that names no table. In both cases a sticky error flag is raised and stays set until reset.

Top module: `tblrt_router`

## Requirements
- R1: Each input port has its own first-in first-out queue that holds up to 8 packets. A packet is stored when `in_valid` and `in_ready` are both high at a clock edge, and every stored packet leaves the router exactly once.
- R2: `in_ready` of a port is low exactly while its queue holds 8 packets. A packet offered while `in_ready` is low is ignored and leaves the queue contents unchanged.
- R3: At each clock edge the scanner grants the first non-empty queue found by searching upward, with wrap, from the port after the last granted port. The search starts at port 0 after reset, and one packet is granted per cycle whenever any queue is non-empty.
- R4: A packet is 32 bits wide. Bits [31:28] carry the identifier and bits [27:0] carry the payload, and the whole word is forwarded unchanged.
- R5: In the cycle after a grant that hits the table, exactly one `out_valid` bit is high, for one cycle, on the looked-up port. `out_pkt` of that port carries the packet, and every other `out_pkt` lane reads zero.
- R6: Identifiers 0 to 12 have table entries. Table 0 routes identifier i to port i mod 4. Table t, for t from 1 to 4, routes identifier i to port t mod 4 when i mod 4 equals t-1, and to port i mod 4 otherwise.
- R7: A granted packet whose identifier is 13 to 15, or that is granted while `tbl_sel` is 5 to 7, produces no `out_valid`. It still uses its grant and still moves the scan pointer. `route_err` rises in the following cycle and stays high until reset.
- R8: After reset all queues are empty, `in_ready` is high on every port, `out_valid` is zero and `route_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_pkt | input | 4 x 32 | Packet word offered on each input port |
| in_valid | input | 4 | A packet is offered on the port |
| in_ready | output | 4 | The port's queue has room |
| tbl_sel | input | 3 | Selects the active routing table (0 to 4 valid) |
| out_pkt | output | 4 x 32 | Forwarded packet on each output port, zero when idle |
| out_valid | output | 4 | One-cycle pulse marking a forwarded packet |
| route_err | output | 1 | Sticky flag for packets that were dropped |

## Verification
The bench offers packets on all four ports at once. It checks that grants rotate in port order, and that an empty port is skipped rather than costing a cycle. A scanner that restarts at port 0 would starve the high ports. One that idles on empty queues would stretch the delivery gaps.

Saturating every port drives the queues to full. A queue that accepts a ninth packet, or that loses one, changes the number of packets that come out after the drain. A ready signal tied to the wrong fill level shows up at once at `in_ready`.

Every identifier is swept under every select value. A lookup with a swapped table or a wrong fallback rule delivers packets to the wrong lane. A missed drop check raises a stray valid pulse.

The error flag is checked for persistence and for clearing on reset, against a cycle-level reference model running under mixed random traffic.

// File: rtl/tblrt_pkg.sv
package tblrt_pkg;

  // Routing rule shared by every table: returns the output port, or -1 on miss.
  function automatic int route_port(int tsel, int id, int ntab, int nent, int nports);
    int dflt;
    if (tsel >= ntab || id >= nent) return -1;
    dflt = id % nports;
    if (tsel != 0 && dflt == tsel - 1) return tsel % nports;
    return dflt;
  endfunction

  // Rotating increment used by queue pointers and the scan pointer.
  function automatic int wrap_inc(int v, int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/tblrt_fifo.sv
module tblrt_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= AW'(tblrt_pkg::wrap_inc(int'(wr_q), DEPTH));
      if (pop)  rd_q <= AW'(tblrt_pkg::wrap_inc(int'(rd_q), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/tblrt_rr.sv
module tblrt_rr #(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          any,
  output logic [PW-1:0] idx
);
  always_comb begin
    int c;
    any = 1'b0;
    idx = '0;
    // Descending scan so the candidate closest to ptr is written last and wins.
    for (int k = N - 1; k >= 0; k--) begin
      c = (int'(ptr) + k) % N;
      if (req[c]) begin
        any = 1'b1;
        idx = PW'(c);
      end
    end
  end
endmodule

// File: rtl/tblrt_table.sv
module tblrt_table #(
  parameter int NTAB   = 5,
  parameter int NENT   = 13,
  parameter int NPORTS = 4,
  parameter int SEL_W  = 3,
  parameter int ID_W   = 4,
  parameter int PW     = 2
) (
  input  logic [SEL_W-1:0] tsel,
  input  logic [ID_W-1:0]  id,
  output logic             hit,
  output logic [PW-1:0]    port
);
  always_comb begin
    int r;
    r    = tblrt_pkg::route_port(int'(tsel), int'(id), NTAB, NENT, NPORTS);
    hit  = (r >= 0);
    port = hit ? r[PW-1:0] : '0;
  end
endmodule

// File: rtl/tblrt_router.sv
module tblrt_router #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 8,
  parameter int PKT_W  = 32,
  parameter int ID_W   = 4,
  parameter int NTAB   = 5,
  parameter int NENT   = 13,
  parameter int SEL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORTS-1:0][PKT_W-1:0]  in_pkt,
  input  logic [NPORTS-1:0]             in_valid,
  output logic [NPORTS-1:0]             in_ready,
  input  logic [SEL_W-1:0]              tbl_sel,
  output logic [NPORTS-1:0][PKT_W-1:0]  out_pkt,
  output logic [NPORTS-1:0]             out_valid,
  output logic                          route_err
);
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic [NPORTS-1:0]             push, pop, fifo_nonempty;
  logic [NPORTS-1:0][PKT_W-1:0]  fifo_dout;
  logic [NPORTS-1:0][CW-1:0]     fifo_cnt;
  logic [NPORTS*CW-1:0]          fifo_cnt_flat;
  logic                          grant_fire;
  logic [PW-1:0]                 grant_idx, rr_ptr;
  logic [PKT_W-1:0]              head;
  logic                          lk_hit;
  logic [PW-1:0]                 lk_port;

  logic [NPORTS-1:0]             out_en_q;
  logic [PKT_W-1:0]              out_data_q;
  logic                          err_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_in
    assign in_ready[p]      = (fifo_cnt[p] != CW'(DEPTH));
    assign push[p]          = in_valid[p] & in_ready[p];
    assign fifo_nonempty[p] = (fifo_cnt[p] != '0);
    assign pop[p]           = grant_fire && (grant_idx == PW'(p));

    tblrt_fifo #(.W(PKT_W), .DEPTH(DEPTH), .CW(CW)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[p]),
      .din   (in_pkt[p]),
      .pop   (pop[p]),
      .dout  (fifo_dout[p]),
      .count (fifo_cnt[p])
    );
  end

  assign fifo_cnt_flat = fifo_cnt;

  tblrt_rr #(.N(NPORTS), .PW(PW)) u_rr (
    .req (fifo_nonempty),
    .ptr (rr_ptr),
    .any (grant_fire),
    .idx (grant_idx)
  );

  assign head = fifo_dout[grant_idx];

  tblrt_table #(
    .NTAB(NTAB), .NENT(NENT), .NPORTS(NPORTS),
    .SEL_W(SEL_W), .ID_W(ID_W), .PW(PW)
  ) u_tbl (
    .tsel (tbl_sel),
    .id   (head[PKT_W-1 -: ID_W]),
    .hit  (lk_hit),
    .port (lk_port)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en_q   <= '0;
      out_data_q <= '0;
      err_q      <= 1'b0;
      rr_ptr     <= '0;
    end else begin
      out_en_q <= '0;
      if (grant_fire) begin
        out_data_q <= head;
        rr_ptr     <= PW'(tblrt_pkg::wrap_inc(int'(grant_idx), NPORTS));
        if (lk_hit) out_en_q <= NPORTS'(1) << lk_port;
        else        err_q    <= 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_out
    assign out_pkt[p] = out_en_q[p] ? out_data_q : '0;
  end

  assign out_valid = out_en_q;
  assign route_err = err_q;
endmodule

// File: rtl/tblrt_checks.sv
module tblrt_checks #(
  parameter int NP    = 4,
  parameter int DEPTH = 8,
  parameter int PW    = 2,
  parameter int CW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NP-1:0]     in_valid,
  input logic [NP-1:0]     in_ready,
  input logic [NP-1:0]     out_valid,
  input logic              route_err,
  input logic              grant_fire,
  input logic [PW-1:0]     grant_idx,
  input logic [PW-1:0]     rr_ptr,
  input logic              lk_hit,
  input logic [NP-1:0]     fifo_nonempty,
  input logic [NP*CW-1:0]  fifo_cnt_flat
);
  assert_onehot_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  assert_hit_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire && lk_hit |=> $countones(out_valid) == 1);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_fire |=> out_valid == '0);

  assert_work_conserving_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_nonempty) |-> grant_fire);

  assert_grant_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> fifo_nonempty[grant_idx]);

  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> rr_ptr == (($past(grant_idx) == PW'(NP - 1)) ? '0 : $past(grant_idx) + 1'b1));

  assert_miss_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire && !lk_hit |=> (out_valid == '0) && route_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    route_err |=> route_err);

  for (genvar p = 0; p < NP; p++) begin : g_port
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt_flat[p*CW +: CW] <= CW'(DEPTH));

    assert_ignored_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[p] && !in_ready[p] |=> fifo_cnt_flat[p*CW +: CW] <= $past(fifo_cnt_flat[p*CW +: CW]));
  end
endmodule

bind tblrt_router tblrt_checks #(.NP(NPORTS), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .route_err     (route_err),
  .grant_fire    (grant_fire),
  .grant_idx     (grant_idx),
  .rr_ptr        (rr_ptr),
  .lk_hit        (lk_hit),
  .fifo_nonempty (fifo_nonempty),
  .fifo_cnt_flat (fifo_cnt_flat)
);

// File: tb/tblrt_router_tb.sv
module tblrt_router_tb;
  localparam int NP = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic                  rst_n = 1'b0;
  logic [NP-1:0][31:0]   in_pkt = '0;
  logic [NP-1:0]         in_valid = '0;
  logic [NP-1:0]         in_ready;
  logic [2:0]            tbl_sel = '0;
  logic [NP-1:0][31:0]   out_pkt;
  logic [NP-1:0]         out_valid;
  logic                  route_err;

  tblrt_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_pkt(in_pkt), .in_valid(in_valid),
    .in_ready(in_ready), .tbl_sel(tbl_sel), .out_pkt(out_pkt),
    .out_valid(out_valid), .route_err(route_err)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_route(int t, int id);
    int d;
    if (t > 4 || id > 12) return -1;
    d = id % 4;
    if (t >= 1 && d == t - 1) return t % 4;
    return d;
  endfunction

  // Behavioural reference model, updated on every rising edge.
  logic [31:0] mq[NP][$];
  int          m_ptr = 0;
  logic [3:0]  m_en = '0;
  logic [31:0] m_data = '0;
  bit          m_err = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) mq[p].delete();
      m_ptr = 0; m_en = '0; m_data = '0; m_err = 1'b0;
    end else begin
      bit acc[NP];
      for (int p = 0; p < NP; p++) acc[p] = in_valid[p] && (mq[p].size() < DEPTH);
      m_en = '0;
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = (m_ptr + k) % NP;
        if (mq[idx].size() > 0) begin
          logic [31:0] w;
          int r;
          w = mq[idx].pop_front();
          r = ref_route(int'(tbl_sel), int'(w[31:28]));
          m_data = w;
          if (r >= 0) m_en = 4'(1 << r);
          else m_err = 1'b1;
          m_ptr = (idx + 1) % NP;
          break;
        end
      end
      for (int p = 0; p < NP; p++) if (acc[p]) mq[p].push_back(in_pkt[p]);
    end
  end

  bit cmp_on = 1'b1;
  always begin
    @(posedge clk);
    #3;
    if (cmp_on) begin
      logic [3:0] er;
      for (int p = 0; p < NP; p++) er[p] = (mq[p].size() < DEPTH);
      chk(in_ready == er, "R2 in_ready", in_ready, er);
      chk(out_valid == m_en, "R5 out_valid", out_valid, m_en);
      for (int p = 0; p < NP; p++)
        chk(out_pkt[p] == (m_en[p] ? m_data : 32'h0), "R4 out_pkt lane", out_pkt[p], m_en[p] ? m_data : 32'h0);
      chk(route_err == m_err, "R7 route_err", route_err, m_err);
    end
  end

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    summary_and_end();
  end

  initial begin
    int outs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk(in_ready == 4'hF, "R8 ready after reset", in_ready, 4'hF);
    chk(out_valid == 4'h0, "R8 valid after reset", out_valid, 4'h0);
    chk(route_err == 1'b0, "R8 err after reset", route_err, 1'b0);

    // R3: all ports at once, served in order 0..3
    tbl_sel = 3'd0;
    for (int p = 0; p < NP; p++) in_pkt[p] = {4'(p), 28'h0A0000 + 28'(p)};
    in_valid = 4'hF;
    @(negedge clk);
    in_valid = 4'h0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk(out_valid == 4'(1 << p), "R3 rotation order", out_valid, 4'(1 << p));
      chk(out_pkt[p] == {4'(p), 28'h0A0000 + 28'(p)}, "R4 packet intact", out_pkt[p], {4'(p), 28'h0A0000 + 28'(p)});
      @(negedge clk);
    end

    // R3: empty ports are skipped
    in_pkt[1] = {4'd1, 28'h1111111};
    in_pkt[3] = {4'd3, 28'h3333333};
    in_valid = 4'b1010;
    @(negedge clk);
    in_valid = 4'h0;
    @(negedge clk);
    chk(out_valid == 4'b0010, "R3 skip to port 1", out_valid, 4'b0010);
    @(negedge clk);
    chk(out_valid == 4'b1000, "R3 skip to port 3", out_valid, 4'b1000);
    @(negedge clk);

    // R6 / R7: sweep every table select and identifier
    for (int t = 0; t < 8; t++) begin
      for (int id = 0; id < 16; id++) begin
        int r;
        logic [31:0] w;
        r = ref_route(t, id);
        w = {4'(id), 28'($urandom)};
        tbl_sel = 3'(t);
        in_pkt[0] = w;
        in_valid = 4'b0001;
        @(negedge clk);
        in_valid = 4'h0;
        @(negedge clk);
        if (r >= 0) begin
          chk(out_valid == 4'(1 << r), "R6 table route", out_valid, 4'(1 << r));
          chk(out_pkt[r] == w, "R6 routed data", out_pkt[r], w);
        end else begin
          chk(out_valid == 4'h0, "R7 drop no valid", out_valid, 4'h0);
          chk(route_err == 1'b1, "R7 err raised", route_err, 1'b1);
        end
        @(negedge clk);
      end
    end
    chk(route_err == 1'b1, "R7 err sticky", route_err, 1'b1);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(route_err == 1'b0, "R8 err cleared by reset", route_err, 1'b0);

    // R1 / R2: saturate all queues, then drain and count
    tbl_sel = 3'd0;
    in_valid = 4'hF;
    for (int c = 0; c < 24; c++) begin
      for (int p = 0; p < NP; p++) in_pkt[p] = {4'(p), 28'(c * 16 + p)};
      @(negedge clk);
    end
    chk($countones(in_ready) <= 1, "R2 queues full", in_ready, 4'h0);
    outs = 32 - $countones(in_ready);
    in_valid = 4'h0;
    begin
      int seen;
      seen = 0;
      for (int c = 0; c < 45; c++) begin
        @(negedge clk);
        seen += $countones(out_valid);
      end
      chk(seen == outs, "R1 depth eight stored and delivered", seen, outs);
    end

    // Mixed random traffic, reference model compares every cycle
    for (int c = 0; c < 4000; c++) begin
      in_valid = 4'($urandom);
      for (int p = 0; p < NP; p++) in_pkt[p] = $urandom;
      if (c % 16 == 0) tbl_sel = (($urandom % 8) < 7) ? 3'($urandom % 5) : 3'(5 + $urandom % 3);
      if (c == 2000) rst_n = 1'b0;
      if (c == 2003) rst_n = 1'b1;
      @(negedge clk);
    end
    in_valid = 4'h0;
    repeat (40) @(negedge clk);
    cmp_on = 1'b0;
    summary_and_end();
  end
endmodule